// File: doc/BRIEF.md
# Two-User Direct-Sequence Spreading Transmitter

The block spreads two independent user data streams onto a shared channel. Each user has its own three-stage pseudo-noise generator with a fixed reset seed, so the two codes run at different phases. It also has an 8-bit parallel-to-serial data source. The master clock is the chip clock. A chip counter divides it by seven, so every data bit spans exactly one full code period. Each data bit is combined with its user's chips by exclusive-OR. The two spread chips are then summed into a small unsigned channel value.

Software or an upstream block offers a word for each user with a one-cycle load strobe. The offered word waits until the current 8-bit frame ends, and then the source takes it and shifts it out MSB first. If no word was offered during a frame, the next frame carries zeros. All outputs are registered. A bit-start marker flags the first chip of every data bit.

Top module: `ds_spread_tx`

## Requirements
- R1: While rst_ni is low, spread_a_o, spread_b_o, sum_o and bit_start_o are all 0.
- R2: User A's code repeats 1,1,0,0,1,0,1 (chip 0 first); with a zero data bit spread_a_o shows this sequence, chip 0 falling on each bit start.
- R3: User B's code repeats 1,1,1,0,0,1,0 (chip 0 first), aligned to the same bit starts as user A.
- R4: bit_start_o is 1 for exactly one cycle in every seven, on the cycle carrying chip 0; the first output cycle after reset release carries a bit start.
- R5: Each data bit lasts seven chip cycles, and spread = data bit XOR chip. Words are sent MSB (bit 7) first.
- R6: A frame is 8 bits (56 cycles). At each frame end the source reloads from the most recent word strobed during that frame, so the last strobe wins.
- R7: A frame that received no strobe, and the first frame after reset, transmits all-zero data.
- R8: A strobe on the frame's final cycle is loaded directly into the next frame.
- R9: sum_o (2 bits) equals spread_a_o + spread_b_o as an unsigned count (0, 1 or 2) in the same cycle.
- R10: Outputs are registered. The first cycle after reset release presents chip 0 of both codes with data 0, so spread_a_o=1, spread_b_o=1 and sum_o=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master chip clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_a_i | input | 8 | User A data word |
| load_a_i | input | 1 | User A word strobe |
| word_b_i | input | 8 | User B data word |
| load_b_i | input | 1 | User B word strobe |
| spread_a_o | output | 1 | User A spread chip |
| spread_b_o | output | 1 | User B spread chip |
| sum_o | output | 2 | Composite channel value |
| bit_start_o | output | 1 | First chip of a data bit |

## Verification
The assertions take for granted that rst_ni is low from time zero. They also assume that strobes and words are steady around each rising edge; a strobe may be any length. The bench applies reset before the first edge and changes inputs only on falling edges. It also places one strobe exactly on a frame's last cycle to reach the load bypass.

// File: rtl/ds_spread_pkg.sv
package ds_spread_pkg;
  localparam int unsigned CHIPS_PER_BIT = 7;
  localparam int unsigned WORD_W        = 8;
  localparam int unsigned N_USERS       = 2;
  localparam int unsigned LFSR_W        = 3;

  function automatic logic [LFSR_W-1:0] user_seed(input int unsigned u);
    return (u == 0) ? 3'b110 : 3'b111;
  endfunction
endpackage

// File: rtl/spread_timer.sv
module spread_timer #(
  parameter int unsigned CHIPS  = 7,
  parameter int unsigned BITS   = 8,
  localparam int unsigned CW    = $clog2(CHIPS),
  localparam int unsigned BW    = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] chip_idx_o,
  output logic          bit_last_o,
  output logic          frame_last_o
);
  logic [BW-1:0] bit_idx_q;

  assign bit_last_o   = (chip_idx_o == CW'(CHIPS - 1));
  assign frame_last_o = bit_last_o && (bit_idx_q == BW'(BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_idx_o <= '0;
      bit_idx_q  <= '0;
    end else if (bit_last_o) begin
      chip_idx_o <= '0;
      bit_idx_q  <= frame_last_o ? '0 : bit_idx_q + 1'b1;
    end else begin
      chip_idx_o <= chip_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/pn_lfsr3.sv
module pn_lfsr3 #(
  parameter logic [2:0] SEED = 3'b110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] state_o,
  output logic       chip_o
);
  // a(n+3) = a(n+1) ^ a(n); state = {a(n), a(n+1), a(n+2)}
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= SEED;
    else         state_o <= {state_o[1], state_o[0], state_o[2] ^ state_o[1]};
  end

  assign chip_o = state_o[2];
endmodule

// File: rtl/piso_source.sv
module piso_source #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         load_i,
  input  logic         bit_last_i,
  input  logic         frame_last_i,
  output logic         data_o
);
  logic [W-1:0] shift_q, pend_q;
  logic         pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (frame_last_i) begin
        // strobe on the reload cycle bypasses the pending register
        shift_q  <= load_i ? word_i : (pend_v_q ? pend_q : '0);
        pend_v_q <= 1'b0;
      end else begin
        if (bit_last_i) shift_q <= {shift_q[W-2:0], 1'b0};
        if (load_i) begin
          pend_q   <= word_i;
          pend_v_q <= 1'b1;
        end
      end
    end
  end

  assign data_o = shift_q[W-1];
endmodule

// File: rtl/ds_spread_tx.sv
module ds_spread_tx
  import ds_spread_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  localparam int unsigned NU   = N_USERS,
  localparam int unsigned SUMW = $clog2(NU + 1),
  localparam int unsigned CW   = $clog2(CHIPS_PER_BIT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    word_a_i,
  input  logic            load_a_i,
  input  logic [W-1:0]    word_b_i,
  input  logic            load_b_i,
  output logic            spread_a_o,
  output logic            spread_b_o,
  output logic [SUMW-1:0] sum_o,
  output logic            bit_start_o
);
  logic [CW-1:0] chip_idx;
  logic          bit_last, frame_last;
  logic [W-1:0]  word    [NU];
  logic [NU-1:0] load;
  logic [NU-1:0] chip, data_bit, spread_d, spread_q;
  logic [2:0]    lfsr_state [NU];
  logic [SUMW-1:0] sum_d;

  assign word[0] = word_a_i;
  assign word[1] = word_b_i;
  assign load    = {load_b_i, load_a_i};

  spread_timer #(.CHIPS(CHIPS_PER_BIT), .BITS(W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chip_idx_o  (chip_idx),
    .bit_last_o  (bit_last),
    .frame_last_o(frame_last)
  );

  for (genvar u = 0; u < NU; u++) begin : g_user
    pn_lfsr3 #(.SEED(user_seed(u))) u_pn (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .state_o(lfsr_state[u]),
      .chip_o (chip[u])
    );
    piso_source #(.W(W)) u_src (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .word_i      (word[u]),
      .load_i      (load[u]),
      .bit_last_i  (bit_last),
      .frame_last_i(frame_last),
      .data_o      (data_bit[u])
    );
    assign spread_d[u] = chip[u] ^ data_bit[u];
  end

  always_comb begin
    sum_d = '0;
    for (int u = 0; u < NU; u++) sum_d = sum_d + SUMW'(spread_d[u]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spread_q    <= '0;
      sum_o       <= '0;
      bit_start_o <= 1'b0;
    end else begin
      spread_q    <= spread_d;
      sum_o       <= sum_d;
      bit_start_o <= (chip_idx == '0);
    end
  end

  assign spread_a_o = spread_q[0];
  assign spread_b_o = spread_q[1];
endmodule

// File: rtl/ds_spread_tx_chk.sv
module ds_spread_tx_chk #(
  parameter int unsigned CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          spread_a_o,
  input logic          spread_b_o,
  input logic [1:0]    sum_o,
  input logic          bit_start_o,
  input logic [CW-1:0] chip_idx,
  input logic          bit_last,
  input logic [2:0]    lfsr_a,
  input logic [2:0]    lfsr_b,
  input logic          data_a
);
  logic [2:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= 3'd5;
    else if (bit_start_o) gap_q <= 3'd0;
    else if (gap_q < 3'd6) gap_q <= gap_q + 3'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!spread_a_o && !spread_b_o && sum_o == 2'd0 && !bit_start_o));

  a_r9_sum_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o == ({1'b0, spread_a_o} + {1'b0, spread_b_o}));

  a_r4_marker_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o == (gap_q == 3'd6));

  a_r2_r3_phase_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_idx == '0) |-> (lfsr_a == 3'b110 && lfsr_b == 3'b111));

  a_r5_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_last |=> $stable(data_a));
endmodule

bind ds_spread_tx ds_spread_tx_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .spread_a_o (spread_a_o),
  .spread_b_o (spread_b_o),
  .sum_o      (sum_o),
  .bit_start_o(bit_start_o),
  .chip_idx   (chip_idx),
  .bit_last   (bit_last),
  .lfsr_a     (lfsr_state[0]),
  .lfsr_b     (lfsr_state[1]),
  .data_a     (data_bit[0])
);

// File: tb/ds_spread_tx_test.sv
`timescale 1ns/1ps
module ds_spread_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] word_a = '0, word_b = '0;
  logic       load_a = 1'b0, load_b = 1'b0;
  logic       spread_a, spread_b, bit_start;
  logic [1:0] sum;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ds_spread_tx uut (
    .clk_i(clk), .rst_ni(rst_n),
    .word_a_i(word_a), .load_a_i(load_a),
    .word_b_i(word_b), .load_b_i(load_b),
    .spread_a_o(spread_a), .spread_b_o(spread_b),
    .sum_o(sum), .bit_start_o(bit_start)
  );

  // requirement-level model: codes listed chip 0 first from the MSB
  localparam logic [6:0] CODE_A = 7'b1100101;
  localparam logic [6:0] CODE_B = 7'b1110010;
  int         m_chip, m_bit;
  logic [7:0] m_sh_a, m_sh_b, m_pd_a, m_pd_b;
  logic       m_pv_a, m_pv_b;
  logic       e_a, e_b, e_bs;
  logic [1:0] e_sum;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chip = 0; m_bit = 0;
      m_sh_a = '0; m_sh_b = '0; m_pd_a = '0; m_pd_b = '0;
      m_pv_a = 0; m_pv_b = 0;
      e_a = 0; e_b = 0; e_bs = 0; e_sum = 0;
    end else begin
      e_a   = CODE_A[6-m_chip] ^ m_sh_a[7];
      e_b   = CODE_B[6-m_chip] ^ m_sh_b[7];
      e_sum = {1'b0, e_a} + {1'b0, e_b};
      e_bs  = (m_chip == 0);
      if (m_chip == 6 && m_bit == 7) begin
        m_sh_a = load_a ? word_a : (m_pv_a ? m_pd_a : 8'h00);
        m_sh_b = load_b ? word_b : (m_pv_b ? m_pd_b : 8'h00);
        m_pv_a = 0; m_pv_b = 0;
      end else begin
        if (m_chip == 6) begin m_sh_a = m_sh_a << 1; m_sh_b = m_sh_b << 1; end
        if (load_a) begin m_pd_a = word_a; m_pv_a = 1; end
        if (load_b) begin m_pd_b = word_b; m_pv_b = 1; end
      end
      if (m_chip == 6) begin m_chip = 0; m_bit = (m_bit + 1) % 8; end
      else m_chip = m_chip + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs against the model for n cycles (at falling edges)
  task automatic run_check(input int n, input string data_req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(spread_a == e_a, {data_req, " R2 user A"}, spread_a, e_a);
      check(spread_b == e_b, {data_req, " R3 user B"}, spread_b, e_b);
      check(sum == e_sum, "R9 sum", sum, e_sum);
      check(bit_start == e_bs, "R4 bit start", bit_start, e_bs);
    end
  endtask

  task automatic wait_bit(input int b);
    while (!(m_chip == 0 && m_bit == b)) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(spread_a == 0 && spread_b == 0, "R1 spreads in reset", {spread_a, spread_b}, 0);
    check(sum == 0 && bit_start == 0, "R1 sum/marker in reset", {sum, bit_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(spread_a == 1 && spread_b == 1, "R10 first chip pair", {spread_a, spread_b}, 3);
    check(sum == 2, "R10 first sum", sum, 2);
    check(bit_start == 1, "R4 first marker", bit_start, 1);
  endtask

  task automatic test_idle_codes();
    // frame 0 carries zeros: spreads show raw codes (R7)
    run_check(54, "R7");
  endtask

  task automatic test_word_load();
    wait_bit(2);
    word_a = 8'hA5; word_b = 8'h3C; load_a = 1; load_b = 1;
    run_check(1, "R6");
    load_a = 0; load_b = 0; word_a = 8'hFF; word_b = 8'hFF;
    run_check(120, "R5 R6");
  endtask

  task automatic test_last_wins();
    wait_bit(1);
    word_a = 8'h0F; load_a = 1; run_check(1, "R6");
    load_a = 0; run_check(10, "R6");
    word_a = 8'hC3; load_a = 1; run_check(1, "R6");
    load_a = 0; word_a = 8'h00;
    run_check(112, "R6 last wins");
  endtask

  task automatic test_zero_fill();
    run_check(60, "R7 zero frame");
  endtask

  task automatic test_bypass();
    while (!(m_chip == 6 && m_bit == 7)) @(negedge clk);
    word_a = 8'h81; word_b = 8'h7E; load_a = 1; load_b = 1;
    run_check(1, "R8");
    load_a = 0; load_b = 0;
    run_check(60, "R8 bypass");
  endtask

  task automatic test_reset_midstream();
    wait_bit(3);
    word_a = 8'h55; load_a = 1; run_check(1, "R6");
    load_a = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check(sum == 0 && bit_start == 0 && !spread_a && !spread_b, "R1 mid reset", sum, 0);
    rst_n = 1'b1;
    run_check(70, "R7 after reset");
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_idle_codes();
    test_word_load();
    test_last_wins();
    test_zero_fill();
    test_bypass();
    test_reset_midstream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule